// File: doc/BRIEF.md
# Dual Gated 13-bit Timer/Counter

This block holds two identical 13-bit timer/counters. Each count is split across two bytes: the five least significant bits of a low byte act as a divide-by-32 prescaler, and an 8-bit high byte counts the prescaler wraps. The top three bits of each low byte are storage only and have no part in counting. When a count wraps from all ones to zero, that counter's overflow flag is set and drives an interrupt request line.

Each counter advances once per count tick. The tick is either a one-cycle internal enable pulse (`tick_i`) or a falling edge seen on that counter's external count pin. Counting is allowed only while the counter's run bit is set and, if its gate bit is set, its external gate pin is high. This lets software measure the width of a pulse on the gate pin. The gate pins and count pins each pass through a two-flop synchronizer. Software uses a small write/read register port to reach a shared mode byte, a control byte with run bits and flags, and the four count bytes. Control and status pins are plain level signals. No data stream crosses the boundary, so the block has no valid/ready handshake and never exerts back-pressure.

Top module: `tmr13_pair`

## Requirements
- R1: A counter's 13-bit value is {high byte, low byte bits [4:0]}. Each increment adds one to low bits [4:0]. When those bits wrap from 31 to 0, the high byte also increments.
- R2: Low byte bits [7:5] keep the last value written to them and read back unchanged. They never alter the count or the overflow.
- R3: An increment taken at count 13'h1FFF gives count 0 and sets the counter's flag. `irq_o[i]` always shows flag i.
- R4: A counter increments on a tick only when its run bit is 1 and either its gate bit is 0 or its synchronized gate pin is 1. The gate bits are mode bit 3 (counter 0) and mode bit 7 (counter 1).
- R5: Setting a run bit does not clear the count. Counting resumes from the held value.
- R6: The tick-source bit is mode bit 2 (counter 0) or mode bit 6 (counter 1). When it is 0, the source is `tick_i`. When it is 1, the source is a falling edge of the synchronized `cnt_pin_i[i]`, and `tick_i` is then ignored by that counter.
- R7: A write to either count byte of a counter loads the written byte and cancels that counter's increment in the same cycle.
- R8: A flag stays set until software writes 0 to it or `irq_ack_i[i]` is pulsed. An overflow in the same cycle as a clear leaves the flag set.
- R9: Register addresses are 0 mode, 1 control, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. Control bit i is run bit i and control bit 4+i is flag i. `rdata_o` shows the register at `addr_i`. All registers reset to 0.
- R10: The two counters are independent. Activity on one never changes the other's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count-enable pulse shared by both counters |
| gate_pin_i | input | 2 | External gate pins, one per counter (asynchronous) |
| cnt_pin_i | input | 2 | External count pins, one per counter (asynchronous) |
| irq_ack_i | input | 2 | Interrupt acknowledge pulses that clear the flags |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 2 | Overflow flags used as interrupt requests |

## Verification
A table of preload values and tick bursts drives counter 0. It tells a prescaler wrap into the high byte apart from a full 13-bit wrap, and shows that preset upper low-byte bits are carried through unchanged. The same table covers run bit off, gate closed, and gate open, which separates the three terms of the enable. Directed cases then check that the flag is sticky, that it is cleared by an acknowledge or by a write of 0, and that an overflow wins when it meets an acknowledge in the same cycle. Further directed cases check that a byte write cancels a simultaneous increment, and drive counter 1 from its count pin with its gate bit closed and then open.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
  localparam int NUM_TMR = 2;
  localparam int BYTE_W  = 8;
  localparam int HI_W    = 8;
  localparam int PRE_W   = 5;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = HI_W + PRE_W;
  localparam int FLAG_OFS = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;

  function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
    return ADDR_W'(2 + 2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
    return ADDR_W'(3 + 2 * idx);
  endfunction

  function automatic int gate_bit(input int idx);
    return 4 * idx + 3;
  endfunction

  function automatic int sel_bit(input int idx);
    return 4 * idx + 2;
  endfunction
endpackage

// File: rtl/tmr13_sync.sv
module tmr13_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/tmr13_unit.sv
module tmr13_unit #(
  parameter int BYTE_W = 8,
  parameter int HI_W   = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              gate_en_i,
  input  logic              src_pin_i,
  input  logic              gate_s_i,
  input  logic              cnt_s_i,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic              inc_o,
  output logic              ovf_o
);
  logic              cnt_d_q;
  logic              fall_w;
  logic              allow_w;
  logic              tick_w;
  logic              inc_w;
  logic [PRE_W-1:0]  pre_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_d_q <= 1'b0;
    else        cnt_d_q <= cnt_s_i;
  end

  assign fall_w  = cnt_d_q & ~cnt_s_i;
  assign allow_w = run_i & (~gate_en_i | gate_s_i);
  assign tick_w  = src_pin_i ? fall_w : tick_i;
  assign inc_w   = allow_w & tick_w & ~(wr_lo_i | wr_hi_i);
  assign pre_w   = lo_o[PRE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      if (wr_lo_i)    lo_o <= wdata_i;
      else if (inc_w) lo_o[PRE_W-1:0] <= pre_w + 1'b1;
      if (wr_hi_i)    hi_o <= wdata_i[HI_W-1:0];
      else if (inc_w && (&pre_w)) hi_o <= hi_o + 1'b1;
    end
  end

  assign inc_o = inc_w;
  assign ovf_o = inc_w & (&pre_w) & (&hi_o);
endmodule

// File: rtl/tmr13_pair.sv
module tmr13_pair
  import tmr13_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NUM_TMR-1:0] gate_pin_i,
  input  logic [NUM_TMR-1:0] cnt_pin_i,
  input  logic [NUM_TMR-1:0] irq_ack_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic [BYTE_W-1:0]  mode_q;
  logic [NUM_TMR-1:0] run_q;
  logic [NUM_TMR-1:0] flag_q;
  logic [NUM_TMR-1:0] gate_s_w;
  logic [NUM_TMR-1:0] cnt_s_w;
  logic [NUM_TMR-1:0] ovf_w;
  logic [NUM_TMR-1:0] eff_inc_w;
  logic [NUM_TMR-1:0] wr_cnt_w;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_w;
  logic [BYTE_W-1:0]  lo_w [NUM_TMR];
  logic [HI_W-1:0]    hi_w [NUM_TMR];
  logic               wr_ctrl_w;
  logic [BYTE_W-1:0]  ctrl_w;

  assign wr_ctrl_w = wr_en_i && (addr_i == A_CTRL);

  tmr13_sync #(.W(2 * NUM_TMR)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cnt_pin_i, gate_pin_i}),
    .q_o   ({cnt_s_w, gate_s_w})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_en_i && addr_i == A_MODE) mode_q <= wdata_i;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic wr_lo_w;
    logic wr_hi_w;
    assign wr_lo_w     = wr_en_i && (addr_i == lo_addr(i));
    assign wr_hi_w     = wr_en_i && (addr_i == hi_addr(i));
    assign wr_cnt_w[i] = wr_lo_w | wr_hi_w;

    tmr13_unit #(.BYTE_W(BYTE_W), .HI_W(HI_W), .PRE_W(PRE_W)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q[i]),
      .gate_en_i (mode_q[gate_bit(i)]),
      .src_pin_i (mode_q[sel_bit(i)]),
      .gate_s_i  (gate_s_w[i]),
      .cnt_s_i   (cnt_s_w[i]),
      .tick_i    (tick_i),
      .wr_lo_i   (wr_lo_w),
      .wr_hi_i   (wr_hi_w),
      .wdata_i   (wdata_i),
      .lo_o      (lo_w[i]),
      .hi_o      (hi_w[i]),
      .inc_o     (eff_inc_w[i]),
      .ovf_o     (ovf_w[i])
    );

    assign cnt_w[i] = {hi_w[i], lo_w[i][PRE_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[i]  <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_ctrl_w) run_q[i] <= wdata_i[i];
        flag_q[i] <= ovf_w[i] |
                     (wr_ctrl_w ? wdata_i[FLAG_OFS + i] : (flag_q[i] & ~irq_ack_i[i]));
      end
    end
  end

  always_comb begin
    ctrl_w = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      ctrl_w[i]            = run_q[i];
      ctrl_w[FLAG_OFS + i] = flag_q[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MODE) rdata_o = mode_q;
    if (addr_i == A_CTRL) rdata_o = ctrl_w;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr_i == lo_addr(i)) rdata_o = lo_w[i];
      if (addr_i == hi_addr(i)) rdata_o = BYTE_W'(hi_w[i]);
    end
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/tmr13_chk.sv
module tmr13_chk
  import tmr13_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_TMR-1:0]            irq_o,
  input logic [NUM_TMR-1:0]            irq_ack_i,
  input logic                          wr_ctrl,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_TMR-1:0]            inc,
  input logic [NUM_TMR-1:0]            wr_cnt
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc[i] |=> cnt[i] == CNT_W'($past(cnt[i]) + 1'b1));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc[i] && !wr_cnt[i]) |=> $stable(cnt[i]));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[i] && (&cnt[i])) |=> (irq_o[i] && cnt[i] == '0));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[i] && !irq_ack_i[i] && !wr_ctrl) |=> irq_o[i]);

    // R3
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[i]) |-> ($past(inc[i] && (&cnt[i])) || $past(wr_ctrl)));
  end
endmodule

bind tmr13_pair tmr13_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .irq_ack_i (irq_ack_i),
  .wr_ctrl   (wr_ctrl_w),
  .cnt       (cnt_w),
  .inc       (eff_inc_w),
  .wr_cnt    (wr_cnt_w)
);

// File: tb/sim_tmr13_pair.sv
`timescale 1ns/1ps
module sim_tmr13_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] gate_pin_i = 2'b00;
  logic [1:0] cnt_pin_i = 2'b11;
  logic [1:0] irq_ack_i = 2'b00;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic [1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr13_pair u0 (.*);

  // {run, gate, gpin, lo, hi, ticks, exp_lo, exp_hi, exp_flag}
  localparam int NV = 9;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'd5,  8'h05, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h1F, 8'h00, 8'd1,  8'h00, 8'h01, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h1F, 8'hFF, 8'd1,  8'h00, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b0, 8'hE0, 8'h10, 8'd33, 8'hE1, 8'h11, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'd1,  8'hE0, 8'h00, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h03, 8'h02, 8'd4,  8'h03, 8'h02, 1'b0},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'd4,  8'h00, 8'h00, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'd4,  8'h04, 8'h00, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h1E, 8'h7F, 8'd3,  8'h01, 8'h80, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic toggle1(input int n);
    for (int k = 0; k < n; k++) begin
      cnt_pin_i[1] = 1'b0;
      repeat (4) @(negedge clk);
      cnt_pin_i[1] = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      check("R9 reset reg", r, 0);
    end
    check("R9 reset irq", irq_o, 0);

    // table walk on counter 0 (R1 R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      e = VEC[v];
      wr(3'd0, {4'b0, e[42], 3'b000});
      wr(3'd1, 8'h00);
      wr(3'd2, e[40:33]);
      wr(3'd3, e[32:25]);
      gate_pin_i[0] = e[41];
      repeat (3) @(negedge clk);
      wr(3'd1, {7'b0, e[43]});
      ticks(int'(e[24:17]));
      rd(3'd2, r); check("R1 R2 R5 low byte", r, e[16:9]);
      rd(3'd3, r); check("R1 R4 high byte", r, e[8:1]);
      check("R3 flag", irq_o[0], e[0]);
      rd(3'd1, r); check("R9 ctrl flag bit", r[4], e[0]);
    end
    gate_pin_i[0] = 1'b0;
    wr(3'd0, 8'h00);

    // R10 counter 1 untouched
    rd(3'd4, r); check("R10 low1", r, 0);
    rd(3'd5, r); check("R10 high1", r, 0);
    check("R10 irq1", irq_o[1], 0);

    // R8 sticky, cleared by acknowledge
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    ticks(1);
    repeat (5) @(negedge clk);
    check("R8 sticky", irq_o[0], 1);
    irq_ack_i[0] = 1'b1; @(negedge clk); irq_ack_i[0] = 1'b0;
    check("R8 ack clear", irq_o[0], 0);

    // R8 cleared by writing 0
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    ticks(1);
    check("R8 set again", irq_o[0], 1);
    wr(3'd1, 8'h01);
    check("R8 write clear", irq_o[0], 0);

    // R8 overflow wins over acknowledge
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    tick_i = 1'b1; irq_ack_i[0] = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; irq_ack_i[0] = 1'b0;
    check("R8 set wins", irq_o[0], 1);
    wr(3'd1, 8'h01);

    // R7 write beats increment
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'd2; wdata_i = 8'h0A;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk);
    rd(3'd2, r); check("R7 write priority", r, 8'h0A);
    wr(3'd1, 8'h00);

    // R6 counter 1 from its count pin
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h02);
    ticks(4);
    rd(3'd4, r); check("R6 tick ignored", r, 0);
    toggle1(3);
    rd(3'd4, r); check("R6 pin edges", r, 3);

    // R4 gate of counter 1 (mode bit 7)
    wr(3'd0, 8'hC0);
    gate_pin_i[1] = 1'b0;
    repeat (3) @(negedge clk);
    toggle1(2);
    rd(3'd4, r); check("R4 gate closed", r, 3);
    gate_pin_i[1] = 1'b1;
    repeat (3) @(negedge clk);
    toggle1(1);
    rd(3'd4, r); check("R4 gate open", r, 4);
    check("R10 irq0 untouched", irq_o[0], 0);
    check("R3 irq1 clear", irq_o[1], 0);

    finish_run();
  end
endmodule